// File: doc/BRIEF.md
# Multi-Mode Logic Cell Register

This block is the single storage bit of one programmable logic cell. Its data input is taken from one of three places: the cell's XOR result, a dedicated product term, or the pad input. The bit can behave as a D, T, JK or SR flip-flop, or as a transparent latch. Its clock comes from one of three global clocks or from a product-term clock. An optional product-term clock enable, a selectable asynchronous reset and an optional asynchronous preset act on it.

All `cfg_*` inputs are static configuration and are set before the cell is used. For the JK and SR modes, the selected data input acts as J or S, and a second product term (`term_aux`) acts as K or R. The cell has two outputs, the pad output and the buried feedback. Each one chooses on its own between the stored bit and the combinational XOR result. There is no data stream at the edge of this block, so all of its pins are plain level signals with no handshake.

A dedicated power-on reset clears the bit to 0, whatever the configuration.

Top module: `mcell_reg`

## Requirements
- R1: `cfg_src` selects the data input: 0 selects `xor_in`, 1 selects `term_data`, 2 selects `pin_in`, and 3 also selects `xor_in`.
- R2: In mode 0 (D), the stored bit takes the selected data on the rising edge of the selected clock.
- R3: In mode 1 (T), the stored bit inverts on a rising edge when the selected data is 1, and holds when it is 0.
- R4: In mode 2 (JK), J is the selected data and K is `term_aux`. On a rising edge: 00 holds, 10 sets, 01 clears, 11 inverts.
- R5: In mode 3 (SR), S is the selected data and R is `term_aux`. On a rising edge: 00 holds, 10 sets, 01 clears, and 11 clears (R wins).
- R6: In mode 4 (latch), the bit follows the selected data while the selected clock is high and holds while it is low.
- R7: `cfg_clk` 0, 1 or 2 selects `gclk[0]`, `gclk[1]` or `gclk[2]`, and 3 selects `term_clk`. Edges on clocks that are not selected have no effect.
- R8: With `cfg_ce_use`=1 and a global clock selected, a rising edge is ignored while `term_ce` is 0. With `term_clk` selected, `term_ce` has no effect.
- R9: `cfg_rst` selects the asynchronous reset source: 0 none, 1 `gclr`, 2 `term_rst`, 3 either of them. While the selected source is high, the bit is 0 with no clock.
- R10: With `cfg_pre_use`=1, `term_pre` high forces the bit to 1 with no clock. When a reset and a preset are active together, the bit is 0.
- R11: `por` high clears the bit to 0 asynchronously, in any configuration, and holds it there.
- R12: `pin_out` is `reg_q` when `cfg_pin_reg`=1 and `xor_in` when it is 0. `fb_out` makes the same choice on its own through `cfg_fb_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por | input | 1 | Power-on reset, asynchronous, active high |
| gclk | input | NUM_GCLK | Global clocks |
| gclr | input | 1 | Global clear, active high |
| xor_in | input | 1 | Combinational XOR result of the cell |
| term_data | input | 1 | Dedicated data product term |
| pin_in | input | 1 | Pad input |
| term_aux | input | 1 | K input in JK mode, R input in SR mode |
| term_clk | input | 1 | Product-term clock |
| term_ce | input | 1 | Product-term clock enable |
| term_rst | input | 1 | Product-term asynchronous reset |
| term_pre | input | 1 | Product-term asynchronous preset |
| cfg_src | input | 2 | Data source select |
| cfg_mode | input | 3 | Storage mode (0 D, 1 T, 2 JK, 3 SR, 4 latch) |
| cfg_clk | input | CLK_SELW | Clock source select |
| cfg_ce_use | input | 1 | Use `term_ce` with a global clock |
| cfg_rst | input | 2 | Reset source select |
| cfg_pre_use | input | 1 | Enable the product-term preset |
| cfg_pin_reg | input | 1 | Pad output takes the stored bit |
| cfg_fb_reg | input | 1 | Feedback takes the stored bit |
| reg_q | output | 1 | Stored bit |
| pin_out | output | 1 | Pad output value |
| fb_out | output | 1 | Buried feedback value |

## Verification
The assertions assume that data, enable and configuration inputs are steady whenever the selected clock rises or falls. They also assume that a preset is released together with, or before, an overlapping reset. The stimulus changes inputs only while every clock is low, and it raises a clock only after those inputs have settled. It applies reset and preset pulses while no clock is toggling. It lowers the latch clock only while the latch data is held steady.

// File: rtl/mcell_reg_pkg.sv
package mcell_reg_pkg;

  typedef enum logic [2:0] {
    MODE_D     = 3'd0,
    MODE_T     = 3'd1,
    MODE_JK    = 3'd2,
    MODE_SR    = 3'd3,
    MODE_LATCH = 3'd4
  } store_mode_e;

  typedef enum logic [1:0] {
    SRC_XOR     = 2'd0,
    SRC_TERM    = 2'd1,
    SRC_PIN     = 2'd2,
    SRC_XOR_ALT = 2'd3
  } data_src_e;

  typedef enum logic [1:0] {
    RST_NONE   = 2'd0,
    RST_GLOBAL = 2'd1,
    RST_TERM   = 2'd2,
    RST_EITHER = 2'd3
  } rst_src_e;

endpackage

// File: rtl/mcell_reg_src.sv
module mcell_reg_src
  import mcell_reg_pkg::*;
(
  input  data_src_e sel_i,
  input  logic      xor_i,
  input  logic      term_i,
  input  logic      pin_i,
  output logic      d_o
);
  always_comb begin
    unique case (sel_i)
      SRC_TERM: d_o = term_i;
      SRC_PIN:  d_o = pin_i;
      default:  d_o = xor_i;
    endcase
  end
endmodule

// File: rtl/mcell_reg_next.sv
module mcell_reg_next
  import mcell_reg_pkg::*;
(
  input  store_mode_e mode_i,
  input  logic        q_i,
  input  logic        d_i,
  input  logic        aux_i,
  output logic        nxt_o
);
  always_comb begin
    case (mode_i)
      MODE_T:  nxt_o = q_i ^ d_i;
      MODE_JK: begin
        unique case ({d_i, aux_i})
          2'b00:   nxt_o = q_i;
          2'b10:   nxt_o = 1'b1;
          2'b01:   nxt_o = 1'b0;
          default: nxt_o = ~q_i;
        endcase
      end
      MODE_SR: nxt_o = aux_i ? 1'b0 : (d_i | q_i);
      default: nxt_o = d_i;
    endcase
    if (mode_i == MODE_SR && d_i && aux_i) begin
      assert_sr_clear_wins_R5: assert (nxt_o == 1'b0)
        else $error("SR with both inputs high did not clear");
    end
  end
endmodule

// File: rtl/mcell_reg_clk.sv
module mcell_reg_clk #(
  parameter int NUM_GCLK = 3,
  localparam int SELW = $clog2(NUM_GCLK + 1)
) (
  input  logic [NUM_GCLK-1:0] gclk_i,
  input  logic                term_clk_i,
  input  logic [SELW-1:0]     sel_i,
  input  logic                ce_use_i,
  input  logic                term_ce_i,
  output logic                clk_o,
  output logic                en_o
);
  logic use_global;

  always_comb begin
    clk_o      = term_clk_i;
    use_global = 1'b0;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (sel_i == SELW'(i)) begin
        clk_o      = gclk_i[i];
        use_global = 1'b1;
      end
    end
    en_o = (use_global && ce_use_i) ? term_ce_i : 1'b1;
    if (!use_global) begin
      assert_term_clk_ignores_enable_R8: assert (en_o)
        else $error("clock enable active with product-term clock");
    end
  end
endmodule

// File: rtl/mcell_reg_async.sv
module mcell_reg_async
  import mcell_reg_pkg::*;
(
  input  logic     por_i,
  input  logic     gclr_i,
  input  logic     term_rst_i,
  input  logic     term_pre_i,
  input  rst_src_e rst_sel_i,
  input  logic     pre_use_i,
  output logic     arst_o,
  output logic     apre_o
);
  logic rst_src;

  always_comb begin
    unique case (rst_sel_i)
      RST_GLOBAL: rst_src = gclr_i;
      RST_TERM:   rst_src = term_rst_i;
      RST_EITHER: rst_src = gclr_i | term_rst_i;
      default:    rst_src = 1'b0;
    endcase
  end

  assign arst_o = por_i | rst_src;
  assign apre_o = pre_use_i & term_pre_i;
endmodule

// File: rtl/mcell_reg_store.sv
module mcell_reg_store (
  input  logic clk_i,
  input  logic en_i,
  input  logic arst_i,
  input  logic apre_i,
  input  logic por_i,
  input  logic latch_i,
  input  logic d_i,
  input  logic nxt_i,
  output logic q_o
);
  logic ff_q;
  logic lat_q;
  logic ff_d;

  assign ff_d = en_i ? nxt_i : ff_q;

  always_ff @(posedge clk_i or posedge arst_i or posedge apre_i) begin
    if (arst_i)      ff_q <= 1'b0;
    else if (apre_i) ff_q <= 1'b1;
    else             ff_q <= ff_d;
  end

  always_latch begin
    if (arst_i)                lat_q <= 1'b0;
    else if (apre_i)           lat_q <= 1'b1;
    else if (clk_i && en_i)    lat_q <= d_i;
  end

  assign q_o = latch_i ? lat_q : ff_q;

  assert_reset_holds_zero_R9: assert property (
    @(posedge clk_i) disable iff (por_i) arst_i |-> (q_o == 1'b0))
    else $error("bit not zero under reset");

  assert_preset_holds_one_R10: assert property (
    @(posedge clk_i) disable iff (por_i) (apre_i && !arst_i) |-> (q_o == 1'b1))
    else $error("bit not one under preset");

  assert_latch_follows_R6: assert property (
    @(negedge clk_i) disable iff (por_i)
      (latch_i && en_i && !arst_i && !apre_i) |-> (q_o == d_i))
    else $error("open latch not following data");
endmodule

// File: rtl/mcell_reg.sv
module mcell_reg
  import mcell_reg_pkg::*;
#(
  parameter int NUM_GCLK = 3,
  localparam int CLK_SELW = $clog2(NUM_GCLK + 1)
) (
  input  logic                por,
  input  logic [NUM_GCLK-1:0] gclk,
  input  logic                gclr,
  input  logic                xor_in,
  input  logic                term_data,
  input  logic                pin_in,
  input  logic                term_aux,
  input  logic                term_clk,
  input  logic                term_ce,
  input  logic                term_rst,
  input  logic                term_pre,
  input  logic [1:0]          cfg_src,
  input  logic [2:0]          cfg_mode,
  input  logic [CLK_SELW-1:0] cfg_clk,
  input  logic                cfg_ce_use,
  input  logic [1:0]          cfg_rst,
  input  logic                cfg_pre_use,
  input  logic                cfg_pin_reg,
  input  logic                cfg_fb_reg,
  output logic                reg_q,
  output logic                pin_out,
  output logic                fb_out
);
  store_mode_e mode;
  logic d_sel, nxt, clk_sel, en, arst, apre;

  assign mode = store_mode_e'(cfg_mode);

  mcell_reg_src u_src (
    .sel_i (data_src_e'(cfg_src)),
    .xor_i (xor_in),
    .term_i(term_data),
    .pin_i (pin_in),
    .d_o   (d_sel)
  );

  mcell_reg_next u_next (
    .mode_i(mode),
    .q_i   (reg_q),
    .d_i   (d_sel),
    .aux_i (term_aux),
    .nxt_o (nxt)
  );

  mcell_reg_clk #(.NUM_GCLK(NUM_GCLK)) u_clk (
    .gclk_i    (gclk),
    .term_clk_i(term_clk),
    .sel_i     (cfg_clk),
    .ce_use_i  (cfg_ce_use),
    .term_ce_i (term_ce),
    .clk_o     (clk_sel),
    .en_o      (en)
  );

  mcell_reg_async u_async (
    .por_i     (por),
    .gclr_i    (gclr),
    .term_rst_i(term_rst),
    .term_pre_i(term_pre),
    .rst_sel_i (rst_src_e'(cfg_rst)),
    .pre_use_i (cfg_pre_use),
    .arst_o    (arst),
    .apre_o    (apre)
  );

  mcell_reg_store u_store (
    .clk_i  (clk_sel),
    .en_i   (en),
    .arst_i (arst),
    .apre_i (apre),
    .por_i  (por),
    .latch_i(mode == MODE_LATCH),
    .d_i    (d_sel),
    .nxt_i  (nxt),
    .q_o    (reg_q)
  );

  assign pin_out = cfg_pin_reg ? reg_q : xor_in;
  assign fb_out  = cfg_fb_reg  ? reg_q : xor_in;
endmodule

// File: tb/mcell_reg_tb.sv
module mcell_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       por = 1'b1;
  logic [2:0] gclk = 3'b000;
  logic gclr = 0, xor_in = 0, term_data = 0, pin_in = 0, term_aux = 0;
  logic term_clk = 0, term_ce = 0, term_rst = 0, term_pre = 0;
  logic [1:0] cfg_src = 0;
  logic [2:0] cfg_mode = 0;
  logic [1:0] cfg_clk = 0;
  logic cfg_ce_use = 0;
  logic [1:0] cfg_rst = 0;
  logic cfg_pre_use = 0, cfg_pin_reg = 1, cfg_fb_reg = 1;
  logic reg_q, pin_out, fb_out;

  int checks = 0;
  int errors = 0;

  mcell_reg u_dut (
    .por(por), .gclk(gclk), .gclr(gclr), .xor_in(xor_in),
    .term_data(term_data), .pin_in(pin_in), .term_aux(term_aux),
    .term_clk(term_clk), .term_ce(term_ce), .term_rst(term_rst),
    .term_pre(term_pre), .cfg_src(cfg_src), .cfg_mode(cfg_mode),
    .cfg_clk(cfg_clk), .cfg_ce_use(cfg_ce_use), .cfg_rst(cfg_rst),
    .cfg_pre_use(cfg_pre_use), .cfg_pin_reg(cfg_pin_reg),
    .cfg_fb_reg(cfg_fb_reg), .reg_q(reg_q), .pin_out(pin_out),
    .fb_out(fb_out)
  );

  // {mode, src, xor/term/pin/aux, expected bit after one gclk[0] edge}
  localparam logic [9:0] VEC [0:16] = '{
    {3'd0, 2'd0, 4'b1000, 1'b1},
    {3'd0, 2'd1, 4'b1000, 1'b0},
    {3'd0, 2'd2, 4'b0010, 1'b1},
    {3'd0, 2'd3, 4'b0010, 1'b0},
    {3'd1, 2'd0, 4'b1000, 1'b1},
    {3'd1, 2'd0, 4'b1000, 1'b0},
    {3'd1, 2'd0, 4'b0000, 1'b0},
    {3'd2, 2'd0, 4'b1000, 1'b1},
    {3'd2, 2'd0, 4'b1001, 1'b0},
    {3'd2, 2'd0, 4'b0000, 1'b0},
    {3'd2, 2'd0, 4'b1001, 1'b1},
    {3'd2, 2'd0, 4'b0001, 1'b0},
    {3'd3, 2'd0, 4'b1000, 1'b1},
    {3'd3, 2'd0, 4'b0000, 1'b1},
    {3'd3, 2'd0, 4'b1001, 1'b0},
    {3'd3, 2'd0, 4'b1000, 1'b1},
    {3'd3, 2'd0, 4'b0001, 1'b0}
  };

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic pulse_g(input int idx);
    #1;
    gclk[idx] = 1'b1;
    #HALF;
    gclk[idx] = 1'b0;
    #HALF;
  endtask

  task automatic pulse_t();
    #1;
    term_clk = 1'b1;
    #HALF;
    term_clk = 1'b0;
    #HALF;
  endtask

  task automatic load_d(input logic v);
    cfg_mode = 3'd0; cfg_src = 2'd0; cfg_clk = 2'd0; xor_in = v;
    pulse_g(0);
  endtask

  function automatic string vec_req(input logic [2:0] m, input logic [1:0] s);
    if (m == 3'd1) return "R3";
    if (m == 3'd2) return "R4";
    if (m == 3'd3) return "R5";
    if (s != 2'd0) return "R1";
    return "R2";
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: power-on reset state
    #HALF;
    chk("R11", reg_q, 1'b0);
    xor_in = 1'b1;
    pulse_g(0);
    chk("R11", reg_q, 1'b0);
    por = 1'b0;
    xor_in = 1'b0;
    #HALF;

    for (int i = 0; i < 17; i++) begin
      cfg_mode  = VEC[i][9:7];
      cfg_src   = VEC[i][6:5];
      xor_in    = VEC[i][4];
      term_data = VEC[i][3];
      pin_in    = VEC[i][2];
      term_aux  = VEC[i][1];
      pulse_g(0);
      chk(vec_req(VEC[i][9:7], VEC[i][6:5]), reg_q, VEC[i][0]);
    end
    term_aux = 0; term_data = 0; pin_in = 0;

    // R6: latch
    load_d(1'b0);
    cfg_mode = 3'd4;
    xor_in = 1'b1; #2;
    chk("R6", reg_q, 1'b0);
    gclk[0] = 1'b1; #2;
    chk("R6", reg_q, 1'b1);
    xor_in = 1'b0; #2;
    chk("R6", reg_q, 1'b0);
    gclk[0] = 1'b0; #2;
    xor_in = 1'b1; #2;
    chk("R6", reg_q, 1'b0);

    // R7: clock selection
    load_d(1'b0);
    cfg_clk = 2'd3; xor_in = 1'b1;
    pulse_g(0);
    chk("R7", reg_q, 1'b0);
    pulse_t();
    chk("R7", reg_q, 1'b1);
    cfg_clk = 2'd2; xor_in = 1'b0;
    pulse_g(1);
    chk("R7", reg_q, 1'b1);
    pulse_g(2);
    chk("R7", reg_q, 1'b0);

    // R8: clock enable
    cfg_clk = 2'd0; cfg_ce_use = 1'b1; term_ce = 1'b0; xor_in = 1'b1;
    pulse_g(0);
    chk("R8", reg_q, 1'b0);
    term_ce = 1'b1;
    pulse_g(0);
    chk("R8", reg_q, 1'b1);
    cfg_clk = 2'd3; term_ce = 1'b0; xor_in = 1'b0;
    pulse_t();
    chk("R8", reg_q, 1'b0);
    cfg_ce_use = 1'b0;

    // R9: reset sources
    load_d(1'b1);
    cfg_rst = 2'd0; gclr = 1'b1; #2;
    chk("R9", reg_q, 1'b1);
    gclr = 1'b0;
    cfg_rst = 2'd1; term_rst = 1'b1; #2;
    chk("R9", reg_q, 1'b1);
    term_rst = 1'b0; gclr = 1'b1; #2;
    chk("R9", reg_q, 1'b0);
    gclr = 1'b0;
    load_d(1'b1);
    cfg_rst = 2'd2; term_rst = 1'b1; #2;
    chk("R9", reg_q, 1'b0);
    term_rst = 1'b0;
    load_d(1'b1);
    cfg_rst = 2'd3; gclr = 1'b1; #2;
    chk("R9", reg_q, 1'b0);
    gclr = 1'b0;
    load_d(1'b1);
    term_rst = 1'b1; #2;
    chk("R9", reg_q, 1'b0);
    term_rst = 1'b0;

    // R10: preset and priority
    cfg_rst = 2'd1;
    load_d(1'b0);
    term_pre = 1'b1; #2;
    chk("R10", reg_q, 1'b0);
    term_pre = 1'b0;
    cfg_pre_use = 1'b1; term_pre = 1'b1; #2;
    chk("R10", reg_q, 1'b1);
    xor_in = 1'b0;
    pulse_g(0);
    chk("R10", reg_q, 1'b1);
    gclr = 1'b1; #2;
    chk("R10", reg_q, 1'b0);
    gclr = 1'b0; term_pre = 1'b0; #2;
    chk("R10", reg_q, 1'b0);
    cfg_pre_use = 1'b0; cfg_rst = 2'd0;

    // R11: power-on reset mid-run
    load_d(1'b1);
    por = 1'b1; #2;
    chk("R11", reg_q, 1'b0);
    por = 1'b0; #2;

    // R12: output and feedback selection
    cfg_pin_reg = 1'b0; cfg_fb_reg = 1'b1; xor_in = 1'b1; #2;
    chk("R12", pin_out, 1'b1);
    chk("R12", fb_out, 1'b0);
    cfg_pin_reg = 1'b1; cfg_fb_reg = 1'b0; #2;
    chk("R12", pin_out, 1'b0);
    chk("R12", fb_out, 1'b1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule